// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a down-counting interval timer with a software-visible count. Each pulse on the tick input lowers the count by one while the count is non-zero. A software write to the count sets the live value and, in the same cycle, a hidden reload value that software cannot read back. The timer expires when a tick lowers the count from one. On expiry the counter either stops at zero or, with auto-reload on, goes straight back to the reload value. The value zero never appears in between.

Every expiry sets a sticky status flag. Software clears the flag with a write-one-to-clear mask. The interrupt request is high while the flag is set, the timer's interrupt enable is set and the external global enable input is high. A small control register holds the auto-reload and interrupt-enable bits.

The counter is built around a two-state machine. In HALTED the count is zero and ticks are ignored. In COUNTING the count is non-zero and ticks are applied. Each cycle the machine takes one named transition:
- LOAD_RUN: a write of a non-zero value; the next state is COUNTING.
- LOAD_HALT: a write of zero; the next state is HALTED.
- STEP: a tick on a count above one; the state stays COUNTING.
- EXPIRE_STOP: a tick on a count of one with auto-reload off; the next state is HALTED.
- EXPIRE_RELOAD: a tick on a count of one with auto-reload on; the state stays COUNTING.
- NONE: the machine holds its state.

Top module: `ivl_timer`

## Requirements
- R1: After reset the count, the hidden reload value, the status flag and both control bits are 0, and the interrupt request is low.
- R2: A count write loads the written value, and the count read port shows it in the following cycle.
- R3: A tick on a count greater than 1 lowers the count by exactly one. Without a tick the count holds.
- R4: A zero count ignores ticks: it stays at 0 and no expiry occurs.
- R5: With auto-reload off (control bit 0 = 0), a tick on a count of 1 makes the count 0, and the count stays 0 until the next write.
- R6: With auto-reload on (control bit 0 = 1), a tick on a count of 1 loads the value of the last count write. The count never reads 0.
- R7: Every expiry sets the status flag (status bit 0) to 1.
- R8: The interrupt request equals status flag AND interrupt enable (control bit 1) AND the global enable input.
- R9: A status write is a mask: a 1 in bit 0 clears the flag, and a 0 leaves it unchanged.
- R10: When a count write and a tick fall in the same cycle, the write wins and no expiry occurs.
- R11: When an expiry and a clearing status write fall in the same cycle, the flag ends up set.
- R12: Writing 0 to the count stops it and causes no expiry.
- R13: A control write stores bit 0 (auto-reload) and bit 1 (interrupt enable), and the control read port returns them the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base tick, one cycle per decrement |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Count write data (also sets the reload value) |
| cnt_rdata_o | output | CNT_W | Live count |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 2 | Control data: bit 0 auto-reload, bit 1 interrupt enable |
| ctl_rdata_o | output | 2 | Control register contents |
| sts_we_i | input | 1 | Status mask write strobe |
| sts_wmask_i | input | 1 | Status clear mask, 1 clears the flag |
| sts_rdata_o | output | 1 | Status flag |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The counting path is swept over load values 1 to 5, tick spacings of 1, 2 and 3 cycles, and both auto-reload settings. The expected count and flag are computed from the number of ticks delivered. The sweep separates a correct decrement from an off-by-one expiry, a stop from a reload, and tick gating from free counting. Directed collisions put a write and a tick in the same cycle, and an expiry and a clear in the same cycle; these expose the wrong priority. A write of zero followed by ticks, and all eight combinations of flag, enable and global enable, cover the halt and the interrupt gate.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    // Counter state: HALTED means the count is zero, COUNTING means it is non-zero
    typedef enum logic [0:0] {
        ST_HALTED   = 1'b0,
        ST_COUNTING = 1'b1
    } cnt_state_e;

    // Named transitions of the counter machine
    typedef enum logic [2:0] {
        TR_NONE          = 3'd0,
        TR_LOAD_RUN      = 3'd1,
        TR_LOAD_HALT     = 3'd2,
        TR_STEP          = 3'd3,
        TR_EXPIRE_STOP   = 3'd4,
        TR_EXPIRE_RELOAD = 3'd5
    } cnt_xfer_e;

    localparam int CTL_W = 2;

    // Control fields: bit 1 interrupt enable, bit 0 auto-reload
    typedef struct packed {
        logic irq_en;
        logic auto_rld;
    } ctl_t;

endpackage

// File: rtl/ivl_timer_count.sv
module ivl_timer_count
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             auto_rld_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             event_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e       state_q, state_d;
    cnt_xfer_e        xfer;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rld_q;

    // Next-state and transition selection
    always_comb begin
        state_d = state_q;
        xfer    = TR_NONE;
        unique case (state_q)
            ST_HALTED: begin
                if (we_i) begin
                    if (wdata_i != CNT_ZERO) begin
                        xfer    = TR_LOAD_RUN;
                        state_d = ST_COUNTING;
                    end else begin
                        xfer    = TR_LOAD_HALT;
                    end
                end
            end
            ST_COUNTING: begin
                if (we_i) begin
                    if (wdata_i != CNT_ZERO) begin
                        xfer    = TR_LOAD_RUN;
                    end else begin
                        xfer    = TR_LOAD_HALT;
                        state_d = ST_HALTED;
                    end
                end else if (tick_i) begin
                    if (cnt_q != CNT_ONE) begin
                        xfer = TR_STEP;
                    end else if (auto_rld_i) begin
                        xfer = TR_EXPIRE_RELOAD;
                    end else begin
                        xfer    = TR_EXPIRE_STOP;
                        state_d = ST_HALTED;
                    end
                end
            end
            default: begin
                state_d = ST_HALTED;
            end
        endcase
    end

    // Datapath driven by the chosen transition
    always_comb begin
        cnt_d = cnt_q;
        unique case (xfer)
            TR_LOAD_RUN:      cnt_d = wdata_i;
            TR_LOAD_HALT:     cnt_d = CNT_ZERO;
            TR_STEP:          cnt_d = cnt_q - CNT_ONE;
            TR_EXPIRE_STOP:   cnt_d = CNT_ZERO;
            TR_EXPIRE_RELOAD: cnt_d = rld_q;
            default:          cnt_d = cnt_q;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
            cnt_q   <= CNT_ZERO;
            rld_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (we_i) begin
                rld_q <= wdata_i;
            end
        end
    end

    // Outputs
    always_comb begin
        cnt_o   = cnt_q;
        event_o = (xfer == TR_EXPIRE_STOP) || (xfer == TR_EXPIRE_RELOAD);
    end

    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cnt_q == $past(wdata_i)));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && tick_i && cnt_q > CNT_ONE) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !tick_i) |=> $stable(cnt_q));

    assert_zero_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && cnt_q == CNT_ZERO) |=> (cnt_q == CNT_ZERO));

    assert_state_matches_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED) == (cnt_q == CNT_ZERO));

    assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !auto_rld_i) |=> (cnt_q == CNT_ZERO));

    assert_reload_no_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && auto_rld_i) |=> (cnt_q == $past(rld_q) && cnt_q != CNT_ZERO));

    assert_write_blocks_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> !event_o);

endmodule

// File: rtl/ivl_timer_status.sv
module ivl_timer_status (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic mask_we_i,
    input  logic mask_i,
    input  logic irq_en_i,
    input  logic gie_i,
    output logic sts_o,
    output logic irq_o
);

    logic sts_q, sts_d;
    logic clr;

    always_comb begin
        clr   = mask_we_i && mask_i;
        sts_d = event_i ? 1'b1 : (sts_q && !clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
        end
    end

    always_comb begin
        sts_o = sts_q;
        irq_o = sts_q && irq_en_i && gie_i;
    end

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> sts_q);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (sts_q && gie_i));

    assert_mask_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && mask_i && !event_i) |=> !sts_q);

    assert_zero_mask_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !(mask_we_i && mask_i)) |=> sts_q);

    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && mask_we_i && mask_i) |=> sts_q);

endmodule

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
    import ivl_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output ctl_t             ctl_o
);

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we_i) begin
            ctl_q <= ctl_t'(wdata_i);
        end
    end

    assign ctl_o = ctl_q;

    assert_ctl_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (ctl_q == ctl_t'($past(wdata_i))));

    assert_ctl_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ctl_q));

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    output logic [CNT_W-1:0] cnt_rdata_o,
    input  logic             ctl_we_i,
    input  logic [1:0]       ctl_wdata_i,
    output logic [1:0]       ctl_rdata_o,
    input  logic             sts_we_i,
    input  logic             sts_wmask_i,
    output logic             sts_rdata_o,
    input  logic             gie_i,
    output logic             irq_o
);

    ctl_t ctl;
    logic expire;

    ivl_timer_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl_we_i),
        .wdata_i (ctl_wdata_i),
        .ctl_o   (ctl)
    );

    ivl_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .we_i       (cnt_we_i),
        .wdata_i    (cnt_wdata_i),
        .auto_rld_i (ctl.auto_rld),
        .cnt_o      (cnt_rdata_o),
        .event_o    (expire)
    );

    ivl_timer_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (expire),
        .mask_we_i (sts_we_i),
        .mask_i    (sts_wmask_i),
        .irq_en_i  (ctl.irq_en),
        .gie_i     (gie_i),
        .sts_o     (sts_rdata_o),
        .irq_o     (irq_o)
    );

    assign ctl_rdata_o = ctl;

    // R12: a zero write never raises the flag by itself
    assert_zero_write_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we_i && cnt_wdata_i == '0 && !sts_rdata_o) |=> !sts_rdata_o);

endmodule

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;

    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             tick;
    logic             cnt_we;
    logic [CNT_W-1:0] cnt_wdata;
    logic [CNT_W-1:0] cnt_rdata;
    logic             ctl_we;
    logic [1:0]       ctl_wdata;
    logic [1:0]       ctl_rdata;
    logic             sts_we;
    logic             sts_wmask;
    logic             sts_rdata;
    logic             gie;
    logic             irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ivl_timer #(.CNT_W(CNT_W)) u_ivl_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cnt_we_i    (cnt_we),
        .cnt_wdata_i (cnt_wdata),
        .cnt_rdata_o (cnt_rdata),
        .ctl_we_i    (ctl_we),
        .ctl_wdata_i (ctl_wdata),
        .ctl_rdata_o (ctl_rdata),
        .sts_we_i    (sts_we),
        .sts_wmask_i (sts_wmask),
        .sts_rdata_o (sts_rdata),
        .gie_i       (gie),
        .irq_o       (irq)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tick = 0; cnt_we = 0; ctl_we = 0; sts_we = 0; sts_wmask = 0;
    endtask

    task automatic write_cnt(input logic [CNT_W-1:0] v);
        cnt_we = 1; cnt_wdata = v; cyc(); cnt_we = 0;
    endtask

    task automatic write_ctl(input logic [1:0] v);
        ctl_we = 1; ctl_wdata = v; cyc(); ctl_we = 0;
    endtask

    task automatic clear_sts();
        sts_we = 1; sts_wmask = 1; cyc(); sts_we = 0; sts_wmask = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; gie = 0; cnt_wdata = '0; ctl_wdata = '0;
        idle_inputs();
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1: reset state
        chk("R1 count", cnt_rdata, 0);
        chk("R1 status", {31'd0, sts_rdata}, 0);
        chk("R1 control", {30'd0, ctl_rdata}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R4/R12: halted count ignores ticks
        write_cnt(0);
        tick = 1;
        repeat (6) cyc();
        tick = 0;
        chk("R4 zero stays", cnt_rdata, 0);
        chk("R12 no event from zero", {31'd0, sts_rdata}, 0);

        // R13: control write readback
        for (int v = 0; v < 4; v++) begin
            write_ctl(v[1:0]);
            chk("R13 control readback", {30'd0, ctl_rdata}, v);
        end

        // Sweep: R2 R3 R5 R6 R7
        for (int ar = 0; ar < 2; ar++) begin
            for (int p = 1; p <= 3; p++) begin
                for (int ld = 1; ld <= 5; ld++) begin
                    int n;
                    logic [CNT_W-1:0] exp;
                    idle_inputs();
                    cnt_we = 1; cnt_wdata = 0;
                    ctl_we = 1; ctl_wdata = {1'b0, ar[0]};
                    sts_we = 1; sts_wmask = 1;
                    cyc();
                    idle_inputs();
                    write_cnt(ld);
                    chk("R2 load readback", cnt_rdata, ld);
                    n = 0;
                    for (int c = 1; c <= 3 * ld * p + 2; c++) begin
                        tick = ((c % p) == 0);
                        cyc();
                        if (tick) n++;
                        if (ar == 0)
                            exp = (n >= ld) ? 0 : ld - n;
                        else
                            exp = ((n % ld) == 0) ? ld : ld - (n % ld);
                        chk(ar == 0 ? "R3/R5 count" : "R3/R6 count", cnt_rdata, exp);
                        chk("R7 status", {31'd0, sts_rdata}, (n >= ld) ? 1 : 0);
                    end
                    tick = 0;
                end
            end
        end

        // R12: write zero mid-count halts, no event
        idle_inputs();
        write_ctl(2'b00);
        clear_sts();
        write_cnt(3);
        tick = 1; cyc();
        tick = 0;
        chk("R3 one step", cnt_rdata, 2);
        write_cnt(0);
        tick = 1;
        repeat (5) cyc();
        tick = 0;
        chk("R12 halted count", cnt_rdata, 0);
        chk("R12 no event", {31'd0, sts_rdata}, 0);

        // R10: write and tick in the same cycle on count 1
        write_cnt(1);
        tick = 1; cnt_we = 1; cnt_wdata = 4;
        cyc();
        tick = 0; cnt_we = 0;
        chk("R10 write wins", cnt_rdata, 4);
        chk("R10 no event", {31'd0, sts_rdata}, 0);

        // R11: expiry and clear in the same cycle
        write_cnt(1);
        tick = 1; sts_we = 1; sts_wmask = 1;
        cyc();
        idle_inputs();
        chk("R11 set wins", {31'd0, sts_rdata}, 1);

        // R9: mask of 0 keeps, mask of 1 clears
        sts_we = 1; sts_wmask = 0; cyc(); idle_inputs();
        chk("R9 zero mask keeps", {31'd0, sts_rdata}, 1);

        // R8: interrupt gate with the flag set and clear
        for (int s = 1; s >= 0; s--) begin
            if (s == 0) clear_sts();
            for (int ie = 0; ie < 2; ie++) begin
                write_ctl({ie[0], 1'b0});
                for (int g = 0; g < 2; g++) begin
                    gie = g[0];
                    #1;
                    chk("R8 irq gate", {31'd0, irq}, s & ie & g);
                end
            end
            if (s == 1) chk("R9 one mask clears (pre)", {31'd0, sts_rdata}, 1);
        end
        chk("R9 one mask clears", {31'd0, sts_rdata}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule